// File: doc/BRIEF.md
# Dual-Channel Wiper Register Bank with One-Hot Tap Select

This block keeps the wiper state of two independent digital potentiometer channels. Each channel owns one active wiper register and four preset registers, all six bits wide. A host reaches these registers through command strobes that arrive from a serial front end. It can load or read the active wiper and any preset, and it can copy a chosen preset into the active wiper in a single command.

For every channel, the active wiper value is decoded into a 64-bit one-hot tap-select vector. This vector drives the switch controls of a resistor string with 63 segments. Bit 0 is the low-end terminal and bit 63 is the high-end terminal. The decode is exhaustive, so exactly one switch per channel is enabled at every cycle after reset, including the cycle in which the wiper changes.

Commands use a valid/ready stream. A command is taken on a rising clock edge when `cmd_valid` and `cmd_ready` are both high. Read results leave on a second valid/ready stream. A read result stays on `rd_data`, unchanged, until the edge where `rd_ready` is high. While a read result is waiting, `cmd_ready` is low, so a new command cannot overtake an unread result. A host that keeps `rd_ready` high can issue one read every two cycles and one write or copy every cycle.

Top module: `wiper_bank`

## Requirements
- R1: After reset, every wiper and preset register of both channels is 0, both tap vectors equal 64'h1, `rd_valid` is low and `cmd_ready` is high.
- R2: Each command carries a 3-bit opcode: 1 loads the wiper, 2 reads the wiper, 3 loads a preset, 4 reads a preset, 5 copies a preset into the wiper. Opcodes 0, 6 and 7 change no register and produce no read result.
- R3: A wiper load stores `cmd_data[5:0]` in the wiper of channel `cmd_chan`. `cmd_data[7:6]` is ignored, and the other channel is not changed.
- R4: A preset load stores `cmd_data[5:0]` in preset `cmd_idx` (0 to 3) of channel `cmd_chan` and leaves every other register unchanged.
- R5: A copy loads preset `cmd_idx` of channel `cmd_chan` into that channel's wiper. The preset keeps its value.
- R6: A read raises `rd_valid` in the cycle after the command is taken. `rd_data` then holds the addressed 6-bit register with bits 7:6 zero.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` stays stable and `cmd_ready` stays low. `rd_valid` falls after the edge where `rd_ready` is high.
- R8: `tap_sel[c]` has exactly one bit set at all times after reset, and that bit is the bit at the position given by the wiper of channel c.
- R9: A tap vector changes only at the edge where a command that loads that channel's wiper is taken. In all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_chan | input | 1 | Channel select |
| cmd_idx | input | 2 | Preset register index |
| cmd_data | input | 8 | Write data; bits 5:0 used |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Host takes read result |
| rd_data | output | 8 | Read result, zero-extended |
| tap_sel | output | 2x64 | One-hot tap select per channel, [1] is channel 1 |

## Verification
A wrong wiper value shows up on `tap_sel` in the cycle after the command that caused it, because the tap vector is a direct decode of the wiper. A corrupted preset stays hidden until it is read back or copied, so the bench reads every register after random traffic and after each ignored opcode. Errors in read handshaking show up within the stall window: `rd_data` changes, or `cmd_ready` goes high while a result is still waiting.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int WB_SEL_W  = 6;
  localparam int WB_NTAP   = 1 << WB_SEL_W;
  localparam int WB_NREG   = 4;
  localparam int WB_IDX_W  = $clog2(WB_NREG);
  localparam int WB_NCH    = 2;
  localparam int WB_CH_W   = $clog2(WB_NCH);
  localparam int WB_DW     = 8;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_WIPER = 3'd2,
    OP_WR_PRE   = 3'd3,
    OP_RD_PRE   = 3'd4,
    OP_COPY     = 3'd5
  } wb_op_e;
endpackage

// File: rtl/wb_tap_decode.sv
module wb_tap_decode #(
  parameter int SEL_W = 6,
  localparam int NTAP = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [NTAP-1:0]  onehot
);
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign onehot[t] = (sel == SEL_W'(t));
  end
endmodule

// File: rtl/wb_channel.sv
module wb_channel #(
  parameter int SEL_W = 6,
  parameter int NREG  = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_wiper,
  input  logic                       we_pre,
  input  logic                       copy,
  input  logic [IDX_W-1:0]           idx,
  input  logic [SEL_W-1:0]           wdata,
  output logic [SEL_W-1:0]           wiper,
  output logic [NREG-1:0][SEL_W-1:0] pre
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper <= '0;
      pre   <= '0;
    end else begin
      if (we_pre) pre[idx] <= wdata;
      if (we_wiper)  wiper <= wdata;
      else if (copy) wiper <= pre[idx];
    end
  end
endmodule

// File: rtl/wb_read_port.sv
module wb_read_port #(
  parameter int SEL_W = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] value,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= DW'(value);
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wb_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  output logic                              cmd_ready,
  input  logic [2:0]                        cmd_op,
  input  logic [WB_CH_W-1:0]                cmd_chan,
  input  logic [WB_IDX_W-1:0]               cmd_idx,
  input  logic [WB_DW-1:0]                  cmd_data,
  output logic                              rd_valid,
  input  logic                              rd_ready,
  output logic [WB_DW-1:0]                  rd_data,
  output logic [WB_NCH-1:0][WB_NTAP-1:0]    tap_sel
);
  wb_op_e op;
  logic   take;
  logic   rd_req;
  logic   unused_hi;
  logic [WB_SEL_W-1:0]                           wdata;
  logic [WB_NCH-1:0][WB_SEL_W-1:0]               wiper;
  logic [WB_NCH-1:0][WB_NREG-1:0][WB_SEL_W-1:0]  pre;
  logic [WB_SEL_W-1:0]                           rd_src;

  assign op        = wb_op_e'(cmd_op);
  assign cmd_ready = !rd_valid;
  assign take      = cmd_valid && cmd_ready;
  assign wdata     = cmd_data[WB_SEL_W-1:0];
  assign unused_hi = ^cmd_data[WB_DW-1:WB_SEL_W];
  assign rd_req    = take && (op == OP_RD_WIPER || op == OP_RD_PRE);
  assign rd_src    = (op == OP_RD_WIPER) ? wiper[cmd_chan] : pre[cmd_chan][cmd_idx];

  for (genvar c = 0; c < WB_NCH; c++) begin : g_ch
    logic hit;
    assign hit = take && (cmd_chan == WB_CH_W'(c));

    wb_channel #(.SEL_W(WB_SEL_W), .NREG(WB_NREG)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_wiper (hit && op == OP_WR_WIPER),
      .we_pre   (hit && op == OP_WR_PRE),
      .copy     (hit && op == OP_COPY),
      .idx      (cmd_idx),
      .wdata    (wdata),
      .wiper    (wiper[c]),
      .pre      (pre[c])
    );

    wb_tap_decode #(.SEL_W(WB_SEL_W)) u_dec (
      .sel    (wiper[c]),
      .onehot (tap_sel[c])
    );
  end

  wb_read_port #(.SEL_W(WB_SEL_W), .DW(WB_DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_req),
    .value    (rd_src),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk
  import wb_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cmd_valid,
  input logic                           cmd_ready,
  input logic [2:0]                     cmd_op,
  input logic [WB_CH_W-1:0]             cmd_chan,
  input logic [WB_DW-1:0]               cmd_data,
  input logic                           rd_valid,
  input logic                           rd_ready,
  input logic [WB_DW-1:0]               rd_data,
  input logic [WB_NCH-1:0][WB_NTAP-1:0] tap_sel
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  // R8
  tap0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel[0]) == 1);
  // R8
  tap1_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel[1]) == 1);
  // R7
  stall_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready);
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R6
  rd_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[WB_DW-1:WB_SEL_W] == '0));
  // R3
  wiper_load0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 3'd1 && cmd_chan == 1'b0)
      |=> tap_sel[0] == (64'd1 << $past(cmd_data[WB_SEL_W-1:0])));
  // R9
  tap0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(tap_sel[0]));
  // R9
  tap1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(tap_sel[1]));
endmodule

bind wiper_bank wiper_bank_chk u_chk (.*);

// File: tb/wiper_bank_test.sv
module wiper_bank_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [0:0] cmd_chan = '0;
  logic [1:0] cmd_idx = '0;
  logic [7:0] cmd_data = '0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic [1:0][63:0] tap_sel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [5:0] m_wiper [2];
  logic [5:0] m_pre [2][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_bank uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_tap(input logic [5:0] w);
    return 64'd1 << w;
  endfunction

  task automatic chk_taps(input string req);
    chk(req, tap_sel[0], exp_tap(m_wiper[0]));
    chk(req, tap_sel[1], exp_tap(m_wiper[1]));
  endtask

  // Issue one command; called and returns at a falling edge.
  task automatic cmd(input logic [2:0] op, input logic ch, input logic [1:0] idx,
                     input logic [7:0] d, input int stall);
    logic [5:0] exp_rd;
    bit is_rd;
    is_rd = (op == 3'd2 || op == 3'd4);
    exp_rd = (op == 3'd2) ? m_wiper[ch] : m_pre[ch][idx];
    chk("R7 ready before cmd", {63'd0, cmd_ready}, 64'd1);
    cmd_op = op; cmd_chan = ch; cmd_idx = idx; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    case (op)
      3'd1: m_wiper[ch] = d[5:0];
      3'd3: m_pre[ch][idx] = d[5:0];
      3'd5: m_wiper[ch] = m_pre[ch][idx];
      default: ;
    endcase
    chk("R8 R9 R3 R5 tap after cmd", tap_sel[0], exp_tap(m_wiper[0]));
    chk("R8 R9 R3 R5 tap after cmd", tap_sel[1], exp_tap(m_wiper[1]));
    if (is_rd) begin
      chk("R6 rd_valid", {63'd0, rd_valid}, 64'd1);
      chk("R6 rd_data", {56'd0, rd_data}, {58'd0, exp_rd});
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R7 hold valid", {63'd0, rd_valid}, 64'd1);
        chk("R7 hold data", {56'd0, rd_data}, {58'd0, exp_rd});
        chk("R7 cmd_ready low", {63'd0, cmd_ready}, 64'd0);
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      chk("R7 valid drops", {63'd0, rd_valid}, 64'd0);
    end else begin
      chk("R2 no read result", {63'd0, rd_valid}, 64'd0);
    end
  endtask

  task automatic read_all(input string tag);
    for (int c = 0; c < 2; c++) begin
      cmd(3'd2, c[0], 2'd0, 8'h00, 0);
      for (int i = 0; i < 4; i++) cmd(3'd4, c[0], i[1:0], 8'h00, 0);
    end
    chk_taps(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 2; c++) begin
      m_wiper[c] = '0;
      for (int i = 0; i < 4; i++) m_pre[c][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    chk("R1 cmd_ready", {63'd0, cmd_ready}, 64'd1);
    chk("R1 tap0", tap_sel[0], 64'h1);
    chk("R1 tap1", tap_sel[1], 64'h1);
    read_all("R1 regs zero");

    // R3 directed: top tap, upper bits ignored, other channel untouched
    cmd(3'd1, 1'b0, 2'd0, 8'hFF, 0);
    chk("R3 tap0 end", tap_sel[0], 64'h8000_0000_0000_0000);
    chk("R3 tap1 unchanged", tap_sel[1], 64'h1);
    cmd(3'd1, 1'b1, 2'd3, 8'hC5, 0);
    cmd(3'd2, 1'b1, 2'd0, 8'h00, 2);
    // R4 R5 directed: load presets, copy, preset keeps value
    cmd(3'd3, 1'b0, 2'd2, 8'h80 | 8'd17, 0);
    cmd(3'd3, 1'b1, 2'd1, 8'd63, 0);
    cmd(3'd5, 1'b0, 2'd2, 8'hFF, 0);
    chk("R5 copy tap0", tap_sel[0], 64'd1 << 17);
    cmd(3'd4, 1'b0, 2'd2, 8'h00, 1);
    cmd(3'd5, 1'b1, 2'd1, 8'h00, 0);
    chk("R5 copy tap1", tap_sel[1], 64'h8000_0000_0000_0000);
    cmd(3'd5, 1'b1, 2'd0, 8'h00, 0);
    chk("R5 copy zero preset", tap_sel[1], 64'h1);
    read_all("R4 R5 after directed");

    // R2 ignored opcodes
    for (int k = 0; k < 12; k++) begin
      logic [2:0] bad;
      bad = (k % 3 == 0) ? 3'd0 : ((k % 3 == 1) ? 3'd6 : 3'd7);
      cmd(bad, $urandom_range(1,0) == 1, 2'($urandom), 8'($urandom), 0);
    end
    read_all("R2 ignored ops");

    // Random mix of operations
    for (int k = 0; k < 600; k++) begin
      cmd(3'($urandom_range(7, 0)), $urandom_range(1,0) == 1, 2'($urandom),
          8'($urandom), $urandom_range(3, 0));
    end
    read_all("R3 R4 R5 random final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule